// File: doc/BRIEF.md
# Address-Masked Port Output Register

This block is a small memory-mapped slave that holds an 8-bit port value and drives it straight onto output pins. The write enable for each pin comes from the access address, not from the data or from a separate register. One bus store can therefore set, clear or leave alone any chosen group of pins. Software does not need a read-modify-write sequence, so an interrupt arriving between the read and the write cannot corrupt the port.

The bus delivers a word address, which is the byte address with its two lowest bits removed. The low eight word-address bits are the pin mask; in byte terms they sit at bits [9:2]. The two word-address bits above the mask select the data window, and only window 0 is decoded. A write inside the window loads the masked pins from the write data in a single cycle. A read inside the window returns the port value ANDed with the mask. Read data is registered and appears in the cycle after the strobe.

Top module: `gpio_masked_port`

## Requirements
- R1: While `rst` is high at a clock edge, `port_out` and `bus_rdata` both become 0.
- R2: The mask is `bus_waddr[7:0]`, and mask bit k governs port bit k. The window field is `bus_waddr[9:8]`, and the address is inside the window when this field is 0.
- R3: A write inside the window makes `port_out[k]` equal `bus_wdata[k]` from the next clock edge on, for every k whose mask bit is 1.
- R4: A write inside the window leaves every `port_out` bit whose mask bit is 0 at its previous value.
- R5: Starting from port 0x02, a write with mask 0x0E and data 0x0A gives port 0x0A in one access: bits 1 and 3 are set and bit 2 is cleared.
- R6: A write with mask 0xFF loads all eight port bits from the data.
- R7: A read inside the window puts `port_out & mask` on `bus_rdata` in the next cycle, so unmasked bits read 0. In any cycle that follows a cycle without `bus_re`, `bus_rdata` is 0.
- R8: A write outside the window changes no port bit, and a read outside the window returns 0.
- R9: When a read and a write hit the window in the same cycle, the read returns the port value from before that write.
- R10: A write with mask 0x00 changes no port bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_waddr | input | 10 | Word address: [7:0] is the pin mask, [9:8] is the window select |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data, valid the cycle after `bus_re` |
| port_out | output | 8 | Port pin drive |

## Verification
The assertions assume that the strobes and the address are settled before each clock edge and that reset is asserted at the first edge. They do not assume that a write and a read are mutually exclusive. The bench changes inputs only on the falling edge and holds reset for several cycles at the start. It then sends directed and random accesses that mix in-window and out-of-window addresses, empty and full masks, and simultaneous read and write strobes.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
    parameter int PORT_W  = 8;
    parameter int WADDR_W = 10;
    localparam int SEL_W  = WADDR_W - PORT_W;
    parameter logic [SEL_W-1:0] WIN_ID = '0;

    typedef logic [PORT_W-1:0] port_t;

    typedef struct packed {
        logic  wr_go;
        logic  rd_go;
        logic  rd_miss;
        port_t mask;
    } gm_access_t;

    function automatic port_t merge_masked(port_t cur, port_t nxt, port_t msk);
        return (cur & ~msk) | (nxt & msk);
    endfunction
endpackage

// File: rtl/gm_addr_decode.sv
module gm_addr_decode
    import gpio_mask_pkg::*;
(
    input  logic [WADDR_W-1:0] waddr,
    input  logic               we,
    input  logic               re,
    output gm_access_t         acc
);
    logic hit;

    always_comb begin
        hit         = (waddr[WADDR_W-1:PORT_W] == WIN_ID);
        acc.mask    = waddr[PORT_W-1:0];
        acc.wr_go   = we & hit;
        acc.rd_go   = re & hit;
        acc.rd_miss = re & ~hit;
    end
endmodule

// File: rtl/gm_port_reg.sv
module gm_port_reg
    import gpio_mask_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  gm_access_t acc,
    input  port_t      wdata,
    output port_t      q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (acc.wr_go)
            q <= merge_masked(q, wdata, acc.mask);
    end

    a_r4_unmasked_hold: assert property (@(posedge clk) disable iff (rst)
        acc.wr_go |=> ((q ^ $past(q)) & ~$past(acc.mask)) == '0);

    a_r3_masked_load: assert property (@(posedge clk) disable iff (rst)
        acc.wr_go |=> (q & $past(acc.mask)) == ($past(wdata) & $past(acc.mask)));
endmodule

// File: rtl/gm_read_path.sv
module gm_read_path
    import gpio_mask_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  gm_access_t acc,
    input  port_t      cur,
    output port_t      rdata
);
    always_ff @(posedge clk) begin
        if (rst || !acc.rd_go)
            rdata <= '0;
        else
            rdata <= cur & acc.mask;
    end

    a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !(acc.rd_go) |=> rdata == '0);
endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
    import gpio_mask_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [WADDR_W-1:0] bus_waddr,
    input  logic [PORT_W-1:0]  bus_wdata,
    input  logic               bus_we,
    input  logic               bus_re,
    output logic [PORT_W-1:0]  bus_rdata,
    output logic [PORT_W-1:0]  port_out
);
    gm_access_t acc;

    gm_addr_decode u_dec (
        .waddr (bus_waddr),
        .we    (bus_we),
        .re    (bus_re),
        .acc   (acc)
    );

    gm_port_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .acc   (acc),
        .wdata (bus_wdata),
        .q     (port_out)
    );

    gm_read_path u_rd (
        .clk   (clk),
        .rst   (rst),
        .acc   (acc),
        .cur   (port_out),
        .rdata (bus_rdata)
    );

    // R8: a write outside the window, or no write at all, leaves the pins alone
    a_r8_no_stray_update: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_waddr[WADDR_W-1:PORT_W] == WIN_ID) |=> $stable(port_out));

    a_r8_outside_read_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_waddr[WADDR_W-1:PORT_W] != WIN_ID) |=> bus_rdata == '0);

    // R7 and R9: read data is the pre-write port value under the mask
    a_r7_read_masked: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_waddr[WADDR_W-1:PORT_W] == WIN_ID)
            |=> bus_rdata == ($past(port_out) & $past(bus_waddr[PORT_W-1:0])));

    a_r10_empty_mask: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_waddr[PORT_W-1:0] == '0) |=> $stable(port_out));
endmodule

// File: tb/tb_gpio_masked_port.sv
module tb_gpio_masked_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] bus_waddr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [7:0] bus_rdata;
    logic [7:0] port_out;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] m_port = '0;
    logic [7:0] m_rd   = '0;
    bit done = 0;

    always #4 clk = ~clk;

    gpio_masked_port dut (
        .clk(clk), .rst(rst), .bus_waddr(bus_waddr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .port_out(port_out)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // one bus cycle; inputs driven at negedge, model stepped at posedge,
    // outputs compared at the following negedge
    task automatic cyc(logic [1:0] sel, logic [7:0] msk, logic [7:0] d,
                       logic w, logic r, string req);
        bus_waddr = {sel, msk};
        bus_wdata = d;
        bus_we    = w;
        bus_re    = r;
        @(posedge clk);
        m_rd = (r && sel == 2'b00) ? (m_port & msk) : 8'h00;
        if (w && sel == 2'b00)
            m_port = (m_port & ~msk) | (d & msk);
        @(negedge clk);
        check(req, port_out, m_port);
        check(req, bus_rdata, m_rd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        bus_we = 1'b1; bus_waddr = 10'h0FF; bus_wdata = 8'hFF; bus_re = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", port_out, 8'h00);
        check("R1", bus_rdata, 8'h00);
        rst = 1'b0; bus_we = 1'b0; bus_re = 1'b0;

        cyc(2'b00, 8'h02, 8'h02, 1, 0, "R3");
        check("R4", port_out, 8'h02);
        cyc(2'b00, 8'h0E, 8'h0A, 1, 0, "R5");
        check("R5", port_out, 8'h0A);
        cyc(2'b00, 8'hF0, 8'hFF, 0, 1, "R7");
        check("R7", bus_rdata, 8'h00);
        cyc(2'b00, 8'h0C, 8'h00, 0, 1, "R7");
        check("R7", bus_rdata, 8'h08);
        cyc(2'b00, 8'h00, 8'h00, 0, 0, "R7");
        cyc(2'b00, 8'hFF, 8'h5A, 1, 0, "R6");
        check("R6", port_out, 8'h5A);
        cyc(2'b00, 8'h00, 8'hFF, 1, 0, "R10");
        check("R10", port_out, 8'h5A);
        cyc(2'b01, 8'hFF, 8'h00, 1, 1, "R8");
        check("R8", port_out, 8'h5A);
        check("R8", bus_rdata, 8'h00);
        cyc(2'b11, 8'h0F, 8'h00, 1, 0, "R8");
        cyc(2'b00, 8'hFF, 8'hA5, 1, 1, "R9");
        check("R9", bus_rdata, 8'h5A);
        check("R9", port_out, 8'hA5);
        cyc(2'b00, 8'h81, 8'h00, 1, 0, "R2");
        check("R2", port_out, 8'h24);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            cyc((rv[1:0] == 2'b11) ? 2'b10 : 2'b00, rv[15:8], rv[23:16],
                rv[2], rv[3], "R3");
        end

        cyc(2'b00, 8'h00, 8'h00, 0, 0, "R7");
        rst = 1'b1;
        @(negedge clk);
        check("R1", port_out, 8'h00);
        check("R1", bus_rdata, 8'h00);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule